// File: doc/BRIEF.md
# Serial-In Latched-Output Port Expander

This block turns a single serial data line into a parallel output word. Bits are clocked into a chain of shift stages by a shift strobe. A separate store strobe copies the whole chain into an output latch in one step. Because the parallel outputs follow only the latch, they stay steady while a new word is being shifted in, and they change in a single step when the word is stored. An active-low output enable gates the outputs. Since the design has no analog tri-state drive, the enable appears as a per-bit drive-enable vector. An active-low asynchronous clear empties the shift stages and leaves the latch alone.

The top shift stage comes out on a serial output, so that several expanders can be chained into a wider port. In that arrangement all devices share the strobes, and each device feeds the serial input of the next. Both strobes are ordinary signals sampled in the system clock domain. Each strobe acts once, on the first system clock edge at which it is seen high after being low. For normal use, hold the clear input high and the output enable low.

Top module: `sipo_latch_expander`

## Requirements
- R1: On a shift event the serial input enters stage 0 and every stage k takes the old value of stage k-1, so after WIDTH events the first bit sent sits in stage WIDTH-1 (output bit WIDTH-1 after a store).
- R2: A shift or store strobe that is held high acts only once; it acts again only after it has been seen low.
- R3: On a store event the latch takes all shift stages at once. Between store events the parallel outputs do not change, even while shifting goes on.
- R4: When both strobes rise in the same system clock cycle, the latch takes the shift contents from before that cycle's shift, so it lags by one shift.
- R5: With oe_n_i low, q_o shows the latch and q_en_o is all ones. With oe_n_i high, q_o reads all zeros and q_en_o is all zeros, and the latch keeps its value.
- R6: Pulling clr_n_i low clears every shift stage at once, without waiting for a clock edge. The latch is unaffected and keeps its value until the next store event.
- R7: ser_o always equals shift stage WIDTH-1. An expander fed from it receives each bit one shift event later.
- R8: After rst_n is released, the shift stages, the latch and ser_o are all zero.
- R9: A strobe acts on the first rising system clock edge at which it is sampled high, having been sampled low at the previous edge. The effect is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of all state |
| ser_i | input | 1 | Serial data input |
| shift_clk_i | input | 1 | Shift strobe, acts on its rising transition |
| store_clk_i | input | 1 | Store strobe, acts on its rising transition |
| clr_n_i | input | 1 | Active-low asynchronous clear of the shift stages |
| oe_n_i | input | 1 | Active-low output enable |
| q_o | output | WIDTH | Parallel output word (zeros while disabled) |
| q_en_o | output | WIDTH | Per-bit drive enable |
| ser_o | output | 1 | Cascade output, top shift stage |

## Verification
The bench builds two expanders with WIDTH = 8 and chains them, the second fed from the first one's ser_o. With 8 stages, all 256 words can be shifted through one device and read back after a store. The chain adds a 16-bit path on which the one-event delay of the cascade can be seen. The small width also keeps the held-strobe, same-cycle shift-and-store, asynchronous-clear and output-enable cases short enough to run against known latch contents.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Index of each strobe in the edge detector array
  typedef enum logic [0:0] {
    STRB_SHIFT = 1'b0,
    STRB_STORE = 1'b1
  } strobe_e;

  localparam int unsigned NUM_STROBES = 2;

  // Rising transition from the current sample and the previous one
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/sipo_edge_det.sv
module sipo_edge_det
  import sipo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe_i;
  end

  assign rise_o = rise_of(strobe_i, prev_q);

  // R2: a rise cannot repeat in the very next cycle
  a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             step_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] stages_o
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-1:0] stages_q;
  logic             arst_n;

  assign arst_n = rst_n & clr_n;

  function automatic logic [WIDTH-1:0] next_stages(input logic [WIDTH-1:0] cur,
                                                   input logic din);
    return {cur[TOP-1:0], din};
  endfunction

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     stages_q <= '0;
    else if (step_i) stages_q <= next_stages(stages_q, din_i);
  end

  assign stages_o = stages_q;

  // R1: stage 0 takes the input, the rest move up by one
  a_r1_shift_step: assert property (@(posedge clk) disable iff (!arst_n)
    step_i |=> (stages_q[0] == $past(din_i)) &&
               (stages_q[TOP:1] == $past(stages_q[TOP-1:0])));
  // R2: no movement without a shift event
  a_r2_hold_no_step: assert property (@(posedge clk) disable iff (!arst_n)
    !step_i |=> $stable(stages_q));
  // R6: the clear empties the stages
  a_r6_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (stages_q == '0));
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] held_o
);
  logic [WIDTH-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (load_i) held_q <= src_i;
  end

  assign held_o = held_q;

  // R3: a load takes the source word as it stood at the edge
  a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (held_q == $past(src_i)));
  // R3: no change between loads
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(held_q));
endmodule

// File: rtl/sipo_latch_expander.sv
module sipo_latch_expander
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_i,
  input  logic             shift_clk_i,
  input  logic             store_clk_i,
  input  logic             clr_n_i,
  input  logic             oe_n_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_en_o,
  output logic             ser_o
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [NUM_STROBES-1:0] strobe_in;
  logic [NUM_STROBES-1:0] strobe_rise;
  logic                   shift_evt;
  logic                   store_evt;
  logic [WIDTH-1:0]       shift_word;
  logic [WIDTH-1:0]       latch_word;

  assign strobe_in[STRB_SHIFT] = shift_clk_i;
  assign strobe_in[STRB_STORE] = store_clk_i;

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_edge
    sipo_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_in[g]),
      .rise_o   (strobe_rise[g])
    );
  end

  assign shift_evt = strobe_rise[STRB_SHIFT];
  assign store_evt = strobe_rise[STRB_STORE];

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n_i),
    .step_i   (shift_evt),
    .din_i    (ser_i),
    .stages_o (shift_word)
  );

  sipo_store_reg #(.WIDTH(WIDTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (store_evt),
    .src_i  (shift_word),
    .held_o (latch_word)
  );

  assign q_o    = oe_n_i ? '0 : latch_word;
  assign q_en_o = {WIDTH{~oe_n_i}};
  assign ser_o  = shift_word[TOP];

  // R7: the cascade bit after a shift is the old next-to-top stage
  a_r7_cascade: assert property (@(posedge clk) disable iff (!(rst_n && clr_n_i))
    shift_evt |=> (ser_o == $past(shift_word[TOP-1])));
  // R4: a store in a shift cycle takes the pre-shift word
  a_r4_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && store_evt) |=> (latch_word == $past(shift_word)));
  // R5: disabled outputs drive nothing
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> (q_en_o == '0) && (q_o == '0));
endmodule

// File: tb/sipo_latch_expander_tb.sv
module sipo_latch_expander_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0, sclk = 1'b0, rclk = 1'b0, clr_n = 1'b1, oe_n = 1'b0;
  logic [W-1:0] q_a, qen_a, q_b, qen_b;
  logic ser_a, ser_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sipo_latch_expander #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_i(ser), .shift_clk_i(sclk),
    .store_clk_i(rclk), .clr_n_i(clr_n), .oe_n_i(oe_n),
    .q_o(q_a), .q_en_o(qen_a), .ser_o(ser_a));

  sipo_latch_expander #(.WIDTH(W)) dut2_i (
    .clk(clk), .rst_n(rst_n), .ser_i(ser_a), .shift_clk_i(sclk),
    .store_clk_i(rclk), .clr_n_i(clr_n), .oe_n_i(oe_n),
    .q_o(q_b), .q_en_o(qen_b), .ser_o(ser_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one shift event: strobe high for one cycle, low for one
  task automatic shift_bit(input logic b);
    @(negedge clk); ser = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic store_word();
    @(negedge clk); rclk = 1'b1;
    @(negedge clk); rclk = 1'b0;
  endtask

  // first bit sent ends in the top stage
  task automatic send_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 q", q_a, 0); chk("R8 ser", ser_a, 0); chk("R8 qen", qen_a, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R3 sweep over all words
    prev = '0;
    for (int v = 0; v < 256; v++) begin
      for (int i = W - 1; i >= 0; i--) begin
        shift_bit(v[i]);
        chk("R3 no ripple", q_a, prev);
      end
      chk("R7 ser top", ser_a, v[7]);
      store_word();
      chk("R1 word", q_a, v[7:0]);
      prev = v[7:0];
    end

    // R9: act on first edge after low-to-high
    send_word(8'h00);
    @(negedge clk); ser = 1'b1; sclk = 1'b1;
    @(posedge clk); #1;
    chk("R9 shift edge", ser_a, 0);
    @(negedge clk); sclk = 1'b0; ser = 1'b0;

    // R2: held strobe acts once
    send_word(8'h00);
    @(negedge clk); ser = 1'b1; sclk = 1'b1;
    repeat (5) @(negedge clk);
    ser = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk); rclk = 1'b1;
    repeat (4) @(negedge clk);
    rclk = 1'b0;
    chk("R2 held shift", q_a, 8'h01);
    // held store: a shift afterwards must not reach outputs
    rclk = 1'b1;
    @(negedge clk);
    chk("R2 store once", q_a, 8'h01);
    shift_bit(1'b0);
    chk("R2 held store", q_a, 8'h01);
    @(negedge clk); rclk = 1'b0;

    // R4: both strobes together
    send_word(8'hA5);
    @(negedge clk); ser = 1'b1; sclk = 1'b1; rclk = 1'b1;
    @(negedge clk); sclk = 1'b0; rclk = 1'b0;
    chk("R4 lag", q_a, 8'hA5);
    store_word();
    chk("R4 after", q_a, 8'h4B);

    // R5 output enable
    oe_n = 1'b1; #1;
    chk("R5 q off", q_a, 0); chk("R5 qen off", qen_a, 0);
    oe_n = 1'b0; #1;
    chk("R5 q back", q_a, 8'h4B); chk("R5 qen on", qen_a, 8'hFF);

    // R6 async clear
    send_word(8'hFF);
    @(negedge clk); #3 clr_n = 1'b0; #2;
    chk("R6 async ser", ser_a, 0);
    chk("R6 latch kept", q_a, 8'h4B);
    @(negedge clk); clr_n = 1'b1;
    store_word();
    chk("R6 cleared", q_a, 0);

    // R7 cascade over 16 bits
    for (int i = 15; i >= 0; i--) shift_bit(16'hC3_5A >> i);
    store_word();
    chk("R7 low dev", q_a, 8'h5A);
    chk("R7 high dev", q_b, 8'hC3);
    chk("R7 chain ser", ser_b, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule